// File: doc/BRIEF.md
# Wideband Sample Level Meter

This block watches a stream of 16-bit two's-complement samples and reduces it to a single 32-bit level figure. A host reads that figure and uses it to set gain or attenuation in front of the converter. Three ways of measuring are offered: a running sum of magnitudes over a window, a first-order leaky average with a power-of-two leak, and a peak hold. The magnitude of every accepted sample feeds one 32-bit datapath whose update rule follows the selected mode.

The host programs the block through a single configuration write that carries the mode, the leak factor, a continuous flag and a 16-bit window count N. Each write restarts the measurement. In windowed operation the result register is loaded once every N+2 accepted samples. In continuous operation, which is available for the leaky and peak modes only, it is loaded on every accepted sample. Each load raises `level_valid` for one cycle.

Samples arrive on a valid/ready interface. The block never applies back-pressure. `in_ready` is high in every cycle outside reset, so a sample is taken in each cycle where `in_valid` is high. The one exception is a cycle that also carries a configuration write: the write wins and that sample is discarded. The result port has no handshake. `level_out` holds its value until the next load, and `level_valid` marks the cycle after a load.

Top module: `sig_level_meter`

## Requirements
- R1: The magnitude of a sample is its absolute value, except that -32768 maps to 32767.
- R2: With mode code 00 (integrate), the result is the sum of the magnitudes of the accepted samples in the window.
- R3: With mode code 01 (leaky), each accepted sample updates Y to Y + ((|X|·2^16 − Y) >>> k), computed with an arithmetic (floor) shift. Leak code 00, 01, 10 or 11 selects k = 0, 8, 12 or 16 respectively.
- R4: With mode code 10 or 11 (peak), the stored value becomes the larger of itself and the new magnitude.
- R5: A window spans N+2 accepted samples, for N from 0 to 65535. After the window closes, the next accepted sample starts from a stored value of zero.
- R6: When the continuous flag is set in leaky or peak mode, the result is loaded on every accepted sample. In integrate mode the flag has no effect.
- R7: Only cycles with `in_valid` high change the measurement. Idle cycles neither advance the window nor alter the stored value.
- R8: A configuration write clears the stored value and the window position and keeps `level_out` unchanged. A sample offered in the same cycle is discarded.
- R9: After reset, `level_out` is 0 and `level_valid` is 0. `level_valid` is high for exactly the one cycle after each load, and `level_out` changes only at a load. In windowed operation two loads are never back to back.
- R10: `in_ready` is low while `rst` is high and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe; restarts the measurement |
| cfg_mode | input | 2 | Mode: 00 integrate, 01 leaky, 10/11 peak |
| cfg_leak | input | 2 | Leak shift select: 00→0, 01→8, 10→12, 11→16 |
| cfg_cont | input | 1 | Continuous operation (leaky and peak only) |
| cfg_count | input | 16 | Window count N; the window is N+2 samples |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample ready; high whenever not in reset |
| in_data | input | 16 | Two's-complement sample |
| level_out | output | 32 | Latched level result |
| level_valid | output | 1 | One-cycle pulse after each result load |

## Verification
The integrate mode is first driven with a pair of full-scale negative samples, which shows whether the saturated magnitude is used. It is then driven with mixed-sign values separated by idle gaps, which shows whether gaps are ignored and whether the window length is N+2. A second window of small values confirms that the stored value restarts from zero. The leaky mode is tried with a zero shift, which shows whether the output tracks the input, and with an 8-bit shift, where a step input exposes the rounding of the shift. Peak runs place the largest value in the middle of the window and are repeated in continuous mode with falling and rising inputs. A randomized stream with random gaps, sign and window sizes is compared on every cycle against a behavioural model. A full 65537-sample window at full scale covers the largest interval.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  typedef enum logic [1:0] {
    MODE_INTEG  = 2'b00,
    MODE_LEAKY  = 2'b01,
    MODE_PEAK   = 2'b10,
    MODE_PEAK_B = 2'b11
  } lvl_mode_e;
endpackage

// File: rtl/lvl_mag.sv
// Saturating magnitude of a two's-complement sample.
module lvl_mag #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  output logic [DW-2:0] mag
);
  logic          neg;
  logic          most_neg;
  logic [DW-1:0] inv;

  always_comb begin
    neg      = x[DW-1];
    most_neg = neg & ~(|x[DW-2:0]);
    inv      = ~x + 1'b1;
    if (most_neg)
      mag = '1;
    else if (neg)
      mag = inv[DW-2:0];
    else
      mag = x[DW-2:0];
  end
endmodule

// File: rtl/lvl_next.sv
// Next stored value for each measurement mode.
module lvl_next
  import lvl_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int L1 = 8,
  parameter int L2 = 12,
  parameter int L3 = 16
) (
  input  lvl_mode_e     mode,
  input  logic [1:0]    leak,
  input  logic [DW-2:0] mag,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] nxt
);
  localparam int SH = AW - DW;
  localparam int SHV [4] = '{0, L1, L2, L3};

  logic [AW-1:0]        mag_ext;
  logic signed [AW:0]   diff;
  logic signed [AW:0]   shifted [4];
  logic [AW-1:0]        leaky_val;

  assign mag_ext = {{(AW-DW+1){1'b0}}, mag};
  assign diff    = $signed({2'b00, mag, {SH{1'b0}}}) - $signed({1'b0, base});

  for (genvar g = 0; g < 4; g++) begin : g_leak
    assign shifted[g] = diff >>> SHV[g];
  end

  assign leaky_val = base + shifted[leak][AW-1:0];

  always_comb begin
    unique case (mode)
      MODE_INTEG: nxt = base + mag_ext;
      MODE_LEAKY: nxt = leaky_val;
      default:    nxt = (mag_ext > base) ? mag_ext : base;
    endcase
  end
endmodule

// File: rtl/lvl_window.sv
// Window position counter and fresh-start flag.
module lvl_window #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          win_en,
  input  logic [CW-1:0] limit,
  output logic          last,
  output logic          fresh,
  output logic [CW:0]   cnt
);
  localparam int CNTW = CW + 1;

  logic [CNTW-1:0] limit_ext;

  assign limit_ext = {1'b0, limit} + 1'b1;
  assign last      = step & win_en & (cnt == limit_ext);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      fresh <= 1'b1;
    end else if (step) begin
      if (win_en)
        cnt <= last ? '0 : cnt + 1'b1;
      fresh <= last;
    end
  end
endmodule

// File: rtl/sig_level_meter.sv
// Wideband sample level meter: integrate, leaky average or peak hold.
module sig_level_meter
  import lvl_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int L1 = 8,
  parameter int L2 = 12,
  parameter int L3 = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_leak,
  input  logic          cfg_cont,
  input  logic [CW-1:0] cfg_count,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] level_out,
  output logic          level_valid
);
  lvl_mode_e     mode_q;
  logic [1:0]    leak_q;
  logic          cont_q;
  logic [CW-1:0] count_q;

  logic          fire;
  logic          free_run;
  logic          win_last;
  logic          fresh;
  logic [CW:0]   win_cnt;
  logic [DW-2:0] mag;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] base;
  logic [AW-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_INTEG;
      leak_q  <= '0;
      cont_q  <= 1'b0;
      count_q <= '0;
    end else if (cfg_wr) begin
      mode_q  <= lvl_mode_e'(cfg_mode);
      leak_q  <= cfg_leak;
      cont_q  <= cfg_cont;
      count_q <= cfg_count;
    end
  end

  assign in_ready = ~rst;
  assign fire     = in_valid & in_ready & ~cfg_wr;
  assign free_run = cont_q & (mode_q != MODE_INTEG);
  assign base     = fresh ? '0 : acc_q;

  lvl_mag #(.DW(DW)) u_mag (
    .x   (in_data),
    .mag (mag)
  );

  lvl_next #(.DW(DW), .AW(AW), .L1(L1), .L2(L2), .L3(L3)) u_next (
    .mode (mode_q),
    .leak (leak_q),
    .mag  (mag),
    .base (base),
    .nxt  (nxt)
  );

  lvl_window #(.CW(CW)) u_win (
    .clk    (clk),
    .rst    (rst),
    .clr    (cfg_wr),
    .step   (fire),
    .win_en (~free_run),
    .limit  (count_q),
    .last   (win_last),
    .fresh  (fresh),
    .cnt    (win_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_wr)
      acc_q <= '0;
    else if (fire)
      acc_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_out   <= '0;
      level_valid <= 1'b0;
    end else begin
      level_valid <= 1'b0;
      if (fire && (free_run || win_last)) begin
        level_out   <= nxt;
        level_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/level_meter_chk.sv
module level_meter_chk #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          cfg_wr,
  input logic [AW-1:0] level_out,
  input logic          level_valid,
  input logic [1:0]    mode_q,
  input logic          cont_q,
  input logic [CW-1:0] count_q,
  input logic [CW:0]   cnt
);
  localparam logic [AW-1:0] PEAK_MAX  = AW'((1 << (DW-1)) - 1);
  localparam logic [AW-1:0] LEAKY_LIM = {1'b1, {(AW-1){1'b0}}};

  p_hold_between_loads_r9: assert property (@(posedge clk) disable iff (rst)
    !level_valid |-> $stable(level_out));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (level_valid && !(cont_q && mode_q != 2'b00)) |=> !level_valid);

  p_load_needs_sample_r7: assert property (@(posedge clk) disable iff (rst)
    level_valid |-> $past(in_valid && !cfg_wr));

  p_cfg_no_load_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !level_valid);

  p_peak_range_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && level_valid) |-> level_out <= PEAK_MAX);

  p_leaky_range_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01 && level_valid) |-> level_out < LEAKY_LIM);

  p_window_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= ({1'b0, count_q} + 1'b1));
endmodule

bind sig_level_meter level_meter_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .cfg_wr      (cfg_wr),
  .level_out   (level_out),
  .level_valid (level_valid),
  .mode_q      (mode_q),
  .cont_q      (cont_q),
  .count_q     (count_q),
  .cnt         (win_cnt)
);

// File: tb/sim_sig_level_meter.sv
`timescale 1ns/1ps
module sim_sig_level_meter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  cfg_leak = '0;
  logic        cfg_cont = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [31:0] level_out;
  logic        level_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sig_level_meter u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_leak(cfg_leak), .cfg_cont(cfg_cont), .cfg_count(cfg_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .level_out(level_out), .level_valid(level_valid)
  );

  // Behavioural reference model
  longint m_out, m_acc, m_lim, m_cnt;
  int     m_mode, m_leak;
  bit     m_cont, m_val, m_fresh;

  always @(posedge clk) begin
    longint a, base, nxt, k;
    if (rst) begin
      m_out = 0; m_val = 0; m_acc = 0; m_cnt = 0; m_fresh = 1;
      m_mode = 0; m_leak = 0; m_cont = 0; m_lim = 0;
    end else begin
      m_val = 0;
      if (cfg_wr) begin
        m_mode = cfg_mode; m_leak = cfg_leak; m_cont = cfg_cont;
        m_lim = cfg_count; m_acc = 0; m_cnt = 0; m_fresh = 1;
      end else if (in_valid) begin
        a = longint'($signed(in_data));
        if (a < 0) a = -a;
        if (a > 32767) a = 32767;
        base = m_fresh ? 0 : m_acc;
        if (m_mode == 0) nxt = base + a;
        else if (m_mode == 1) begin
          k = (m_leak == 0) ? 0 : (m_leak == 1) ? 8 : (m_leak == 2) ? 12 : 16;
          nxt = base + (((a * 65536) - base) >>> k);
        end else nxt = (a > base) ? a : base;
        m_acc = nxt;
        if (m_cont && m_mode != 0) begin
          m_out = nxt; m_val = 1; m_fresh = 0;
        end else if (m_cnt == m_lim + 1) begin
          m_out = nxt; m_val = 1; m_cnt = 0; m_fresh = 1;
        end else begin
          m_cnt = m_cnt + 1; m_fresh = 0;
        end
      end
    end
  end

  function automatic string tag_of(int mode);
    if (mode == 0) return "R2";
    if (mode == 1) return "R3";
    return "R4";
  endfunction

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (level_out !== 32'(m_out) || level_valid !== m_val) begin
        fails++;
        $display("FAIL %s/R9 model: out=%0d valid=%0b expected out=%0d valid=%0b",
                 tag_of(m_mode), level_out, level_valid, m_out, m_val);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int v);
    @(negedge clk);
    cfg_wr = 1'b0; in_valid = 1'b1; in_data = 16'(v);
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_wr = 1'b0; in_valid = 1'b0;
  endtask

  task automatic cfg(int mode, int leak, bit cont, int count, bit v = 0, int d = 0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = 2'(mode); cfg_leak = 2'(leak);
    cfg_cont = cont; cfg_count = 16'(count);
    in_valid = v; in_data = 16'(d);
  endtask

  task automatic expect_load(string tag, longint exp);
    idle();
    chk(tag, level_valid, 1);
    chk(tag, level_out, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset out", level_out, 0);
    chk("R9 reset valid", level_valid, 0);
    chk("R10 ready", in_ready, 1);

    // R1: full-scale negative magnitude
    cfg(0, 0, 0, 0);
    send(-32768); send(-32768);
    expect_load("R1", 65534);

    // R2 / R7: window of 4 with idle gaps
    cfg(0, 0, 0, 2);
    send(10); idle(); send(-20); send(30);
    idle(); chk("R7 no early load", level_valid, 0);
    idle(); send(-40);
    expect_load("R2", 100);
    // R5: next window starts from zero
    send(1); send(1); send(1); send(1);
    expect_load("R5", 4);

    // R3: leaky tracking and 8-bit leak
    cfg(1, 0, 0, 0);
    send(100); send(200);
    expect_load("R3 k0", 13107200);
    cfg(1, 1, 0, 0);
    send(256); send(256);
    expect_load("R3 k8", 130816);

    // R4: peak, both codes
    cfg(2, 0, 0, 1);
    send(5); send(-300); send(20);
    expect_load("R4 code10", 300);
    cfg(3, 0, 0, 1);
    send(5); send(-300); send(20);
    expect_load("R4 code11", 300);

    // R6: continuous peak, then flag ignored in integrate mode
    cfg(2, 0, 1, 0);
    send(7); expect_load("R6 cont", 7);
    send(3); expect_load("R6 cont", 7);
    send(9); expect_load("R6 cont", 9);
    cfg(0, 0, 1, 0);
    send(4); idle();
    chk("R6 integrate ignores cont", level_valid, 0);
    chk("R6 integrate out held", level_out, 9);
    send(5); expect_load("R6 integrate window", 9);

    // R8: config write mid-window with a coincident sample
    cfg(0, 0, 0, 1);
    send(50); send(50);
    cfg(0, 0, 0, 1, 1, 999);
    idle();
    chk("R8 out held", level_out, 9);
    chk("R8 no load", level_valid, 0);
    send(1); send(2); send(3);
    expect_load("R8 restart", 6);

    // Randomized streams, checked every cycle by the model
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 4; l++) begin
        cfg(m, l, (l % 2) == 1, $urandom_range(0, 5));
        for (int i = 0; i < 300; i++) begin
          if ($urandom_range(0, 3) == 0) idle();
          else if ($urandom_range(0, 15) == 0) send(-32768);
          else send(int'($urandom_range(0, 65535)));
        end
      end
    end

    // R5: longest window at full scale
    cfg(0, 0, 0, 65535);
    for (int i = 0; i < 65537; i++) send(32767);
    expect_load("R5 max window", 64'd2147450879);

    idle(); idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule